// File: doc/BRIEF.md
# Branch Target Buffer Next-Fetch Predictor

This block guesses the address to fetch after the current one. A fetch stage gives it the PC it is about to issue. In the same cycle the block returns either a remembered target or the sequential address PC + 4. Instructions are 4 bytes wide. The table is direct-mapped, and each slot holds a valid flag, an address tag and a full target address.

When a branch or jump resolves in execute, the pipeline sends its PC and the address that actually followed, together with a strobe. An update classifier sorts each strobe into one of four kinds:

- `UPD_NONE`: no strobe.
- `UPD_ALLOC`: the next address was non-sequential, so the slot is written.
- `UPD_DROP`: the next address was sequential and the slot holds this PC, so the slot is invalidated.
- `UPD_SKIP`: the next address was sequential and the slot holds some other PC, so nothing changes.

An update written on a clock edge affects predictions from the following cycle onward.

Top module: `btb_nextpc`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses with `pred_hit` = 0 and `pred_next` = `pred_pc` + 4.
- R2: On a miss, `pred_next` is `pred_pc` + 4 taken modulo 2^PC_W (0xFFFFFFFC gives 0).
- R3: An update whose `upd_next` differs from `upd_pc` + 4 installs the slot. A later lookup of the same PC then hits, and `pred_next` equals that `upd_next`.
- R4: An update whose `upd_next` equals `upd_pc` + 4 never installs a slot.
- R5: A sequential update whose PC matches the stored tag of its slot invalidates that slot, so the PC then misses.
- R6: A sequential update whose tag differs from the stored tag leaves the slot and its prediction unchanged.
- R7: A non-sequential update to an occupied slot with a different tag replaces it. The old PC then misses and the new PC hits.
- R8: An update presented in a cycle does not change the prediction of that same cycle. It takes effect from the next cycle.
- R9: The slot index is PC[IDX_W+1:2] and the tag is PC[PC_W-1:IDX_W+2]. PC bits 1:0 play no part in matching.
- R10: With `upd_valid` low, the table does not change whatever `upd_pc` and `upd_next` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | PC being fetched |
| pred_next | output | PC_W | Predicted next fetch address |
| pred_hit | output | 1 | A valid slot matched `pred_pc` |
| upd_valid | input | 1 | Resolved control transfer strobe |
| upd_pc | input | PC_W | PC of the resolved instruction |
| upd_next | input | PC_W | Address that actually followed it |

## Verification
The hardest case to reach is the `UPD_SKIP` versus `UPD_DROP` split. Telling them apart needs a sequential update that lands on a slot that is occupied, once with the same tag and once with a different one. Uniform random PCs almost never collide like this.

The stimulus therefore draws PCs from four tags over sixteen slots, so aliasing and re-resolution are frequent. Directed cases build the same-slot, different-tag sequence explicitly. Every random step compares the combinational prediction against a bench model before the clock edge, which exercises the one-cycle visibility rule.

// File: rtl/btb_pkg.sv
package btb_pkg;
    typedef enum logic [1:0] {
        UPD_NONE  = 2'd0,
        UPD_ALLOC = 2'd1,
        UPD_DROP  = 2'd2,
        UPD_SKIP  = 2'd3
    } upd_kind_e;
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int TAG_W = PC_W - 2 - IDX_W
) (
    input  logic [PC_W-1:2]  word_addr,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    // slot index sits just above the byte offset; the rest is tag (R9)
    always_comb begin
        idx = word_addr[IDX_W+1:2];
        tag = word_addr[PC_W-1:IDX_W+2];
    end
endmodule

// File: rtl/btb_update_ctl.sv
module btb_update_ctl #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int TAG_W = PC_W - 2 - IDX_W
) (
    input  logic                   upd_valid,
    input  logic [PC_W-1:0]        upd_pc,
    input  logic [PC_W-1:0]        upd_next,
    input  logic [TAG_W-1:0]       upd_tag,
    input  logic                   slot_valid,
    input  logic [TAG_W-1:0]       slot_tag,
    output btb_pkg::upd_kind_e     kind
);
    import btb_pkg::*;

    logic seq_flow;
    logic owns_slot;

    always_comb begin
        seq_flow  = (upd_next == upd_pc + PC_W'(4));
        owns_slot = slot_valid && (slot_tag == upd_tag);
        unique case ({upd_valid, seq_flow})
            2'b10:   kind = UPD_ALLOC;
            2'b11:   kind = owns_slot ? UPD_DROP : UPD_SKIP;
            default: kind = UPD_NONE;
        endcase
    end
endmodule

// File: rtl/btb_store.sv
module btb_store #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int TAG_W   = PC_W - 2 - IDX_W,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic                rd_valid,
    output logic [TAG_W-1:0]    rd_tag,
    output logic [PC_W-1:0]     rd_tgt,
    input  logic [IDX_W-1:0]    wr_idx,
    input  btb_pkg::upd_kind_e  wr_kind,
    input  logic [TAG_W-1:0]    wr_tag,
    input  logic [PC_W-1:0]     wr_tgt,
    output logic                wr_slot_valid,
    output logic [TAG_W-1:0]    wr_slot_tag,
    output logic [ENTRIES-1:0]  vld_vec
);
    import btb_pkg::*;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [PC_W-1:0]    tgt_q [ENTRIES];

    // valid flags: cleared on reset (R1), set or cleared by the update kind
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            unique case (wr_kind)
                UPD_ALLOC: valid_q[wr_idx] <= 1'b1;
                UPD_DROP:  valid_q[wr_idx] <= 1'b0;
                UPD_SKIP, UPD_NONE: ;
            endcase
        end
    end

    // tag and target payload need no reset
    always_ff @(posedge clk) begin
        if (wr_kind == UPD_ALLOC) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_tgt;
        end
    end

    always_comb begin
        rd_valid      = valid_q[rd_idx];
        rd_tag        = tag_q[rd_idx];
        rd_tgt        = tgt_q[rd_idx];
        wr_slot_valid = valid_q[wr_idx];
        wr_slot_tag   = tag_q[wr_idx];
        vld_vec       = valid_q;
    end
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int TAG_W = PC_W - 2 - IDX_W
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             slot_valid,
    input  logic [TAG_W-1:0] slot_tag,
    input  logic [PC_W-1:0]  slot_tgt,
    output logic             hit,
    output logic [PC_W-1:0]  next_pc
);
    always_comb begin
        hit     = slot_valid && (slot_tag == req_tag);
        next_pc = hit ? slot_tgt : pc + PC_W'(4);
    end
endmodule

// File: rtl/btb_nextpc.sv
module btb_nextpc #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic [PC_W-1:0] pred_next,
    output logic            pred_hit,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_next
);
    import btb_pkg::*;

    localparam int TAG_W   = PC_W - 2 - IDX_W;
    localparam int ENTRIES = 1 << IDX_W;

    logic [IDX_W-1:0]   p_idx, u_idx;
    logic [TAG_W-1:0]   p_tag, u_tag;
    logic               rd_valid, ws_valid;
    logic [TAG_W-1:0]   rd_tag, ws_tag;
    logic [PC_W-1:0]    rd_tgt;
    logic [ENTRIES-1:0] vld_vec;
    upd_kind_e          kind;

    btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_pred (
        .word_addr(pred_pc[PC_W-1:2]), .idx(p_idx), .tag(p_tag));

    btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_upd (
        .word_addr(upd_pc[PC_W-1:2]), .idx(u_idx), .tag(u_tag));

    btb_update_ctl #(.PC_W(PC_W), .IDX_W(IDX_W)) u_ctl (
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_next(upd_next),
        .upd_tag(u_tag), .slot_valid(ws_valid), .slot_tag(ws_tag),
        .kind(kind));

    btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(p_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_tgt(rd_tgt),
        .wr_idx(u_idx), .wr_kind(kind), .wr_tag(u_tag), .wr_tgt(upd_next),
        .wr_slot_valid(ws_valid), .wr_slot_tag(ws_tag), .vld_vec(vld_vec));

    btb_lookup #(.PC_W(PC_W), .IDX_W(IDX_W)) u_lookup (
        .pc(pred_pc), .req_tag(p_tag), .slot_valid(rd_valid),
        .slot_tag(rd_tag), .slot_tgt(rd_tgt),
        .hit(pred_hit), .next_pc(pred_next));
endmodule

// File: rtl/btb_nextpc_chk.sv
module btb_nextpc_chk #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int ENTRIES = 1 << IDX_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PC_W-1:0]    pred_pc,
    input logic [PC_W-1:0]    pred_next,
    input logic               pred_hit,
    input logic               upd_valid,
    input logic [PC_W-1:0]    upd_pc,
    input logic [PC_W-1:0]    upd_next,
    input logic [ENTRIES-1:0] vld_vec
);
    logic             fresh;
    logic [IDX_W-1:0] u_slot;
    logic             nonseq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fresh <= 1'b1;
        else        fresh <= 1'b0;
    end

    always_comb begin
        u_slot = upd_pc[IDX_W+1:2];
        nonseq = upd_next != upd_pc + PC_W'(4);
    end

    a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |-> (vld_vec == '0 && !pred_hit));

    a_r2_miss_seq: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> pred_next == pred_pc + PC_W'(4));

    a_r3_alloc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && nonseq) |=> vld_vec[$past(u_slot)]);

    a_r4_seq_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !nonseq) |=> $countones(vld_vec) <= $past($countones(vld_vec)));

    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(vld_vec));
endmodule

bind btb_nextpc btb_nextpc_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/btb_nextpc_bench.sv
module btb_nextpc_bench;
    localparam int PC_W  = 32;
    localparam int IDX_W = 4;
    localparam int TAG_W = PC_W - 2 - IDX_W;
    localparam int ENT   = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0, upd_pc = '0, upd_next = '0;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] pred_next;
    logic            pred_hit;

    int checks = 0;
    int errors = 0;

    logic             mv [ENT];
    logic [TAG_W-1:0] mt [ENT];
    logic [PC_W-1:0]  mg [ENT];

    always #2.5 clk = ~clk;

    btb_nextpc #(.PC_W(PC_W), .IDX_W(IDX_W)) u_btb_nextpc (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_next(pred_next),
        .pred_hit(pred_hit), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_next(upd_next));

    function automatic logic [IDX_W-1:0] fidx(input logic [PC_W-1:0] a);
        return a[IDX_W+1:2];
    endfunction
    function automatic logic [TAG_W-1:0] ftag(input logic [PC_W-1:0] a);
        return a[PC_W-1:IDX_W+2];
    endfunction
    function automatic logic mhit(input logic [PC_W-1:0] a);
        return mv[fidx(a)] && mt[fidx(a)] == ftag(a);
    endfunction
    function automatic logic [PC_W-1:0] mnext(input logic [PC_W-1:0] a);
        return mhit(a) ? mg[fidx(a)] : a + 32'd4;
    endfunction

    task automatic check(input string req, input logic eh, input logic [PC_W-1:0] en);
        checks++;
        if (pred_hit !== eh || pred_next !== en) begin
            errors++;
            $display("FAIL %s pc=%h: hit=%b next=%h expected hit=%b next=%h",
                     req, pred_pc, pred_hit, pred_next, eh, en);
        end
    endtask

    // drive one cycle, check prediction before the edge, then advance model
    task automatic step(input logic uv, input logic [PC_W-1:0] up, un, pp,
                        input logic eh, input logic [PC_W-1:0] en, input string req);
        @(negedge clk);
        upd_valid = uv; upd_pc = up; upd_next = un; pred_pc = pp;
        #1 check(req, eh, en);
        @(posedge clk);
        if (uv) begin
            if (un != up + 32'd4) begin
                mv[fidx(up)] = 1'b1; mt[fidx(up)] = ftag(up); mg[fidx(up)] = un;
            end else if (mhit(up)) begin
                mv[fidx(up)] = 1'b0;
            end
        end
    endtask

    task automatic look(input logic [PC_W-1:0] pp, input logic eh,
                        input logic [PC_W-1:0] en, input string req);
        step(1'b0, 32'h0, 32'h0, pp, eh, en, req);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [PC_W-1:0] a, b, c;
        void'($urandom(32'd7));
        for (int i = 0; i < ENT; i++) mv[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset across all slots
        for (int i = 0; i < ENT; i++) begin
            a = (32'(i) << 2) | (32'(i) << 9);
            look(a, 1'b0, a + 32'd4, "R1");
        end
        // R2: wraparound on miss
        look(32'hFFFF_FFFC, 1'b0, 32'h0, "R2");

        a = 32'h0000_1000; b = a + 32'd64; c = 32'h0000_2010;
        // R8: same-cycle update invisible; R3: visible next cycle
        step(1'b1, a, 32'h0000_2000, a, 1'b0, a + 32'd4, "R8");
        look(a, 1'b1, 32'h0000_2000, "R3");
        // R9: low PC bits ignored
        look(a | 32'd2, 1'b1, 32'h0000_2000, "R9");
        // R6: sequential update on same slot, other tag, keeps entry
        step(1'b1, b, b + 32'd4, a, 1'b1, 32'h0000_2000, "R6");
        look(a, 1'b1, 32'h0000_2000, "R6");
        // R7: replacement by different tag
        step(1'b1, b, 32'h0000_3000, b, 1'b0, b + 32'd4, "R7");
        look(a, 1'b0, a + 32'd4, "R7");
        look(b, 1'b1, 32'h0000_3000, "R7");
        // R5: sequential resolution clears matching entry
        step(1'b1, b, b + 32'd4, b, 1'b1, 32'h0000_3000, "R5");
        look(b, 1'b0, b + 32'd4, "R5");
        // R4: sequential update never allocates
        step(1'b1, c, c + 32'd4, c, 1'b0, c + 32'd4, "R4");
        look(c, 1'b0, c + 32'd4, "R4");
        // R10: strobe low ignores the update fields
        step(1'b0, c, 32'h0000_7000, c, 1'b0, c + 32'd4, "R10");
        look(c, 1'b0, c + 32'd4, "R10");

        // random mix over four tags and all slots (R3 R5 R6 R7 R10)
        for (int n = 0; n < 3000; n++) begin
            logic            uv;
            logic [PC_W-1:0] up, un, pp;
            uv = ($urandom_range(0, 3) != 0);
            up = (32'($urandom_range(0, 3)) << 6) | (32'($urandom_range(0, ENT-1)) << 2);
            un = $urandom_range(0, 1) ? up + 32'd4 : ($urandom() & 32'hFFFF_FFFC);
            pp = (32'($urandom_range(0, 3)) << 6) | (32'($urandom_range(0, ENT-1)) << 2)
                 | 32'($urandom_range(0, 3));
            step(uv, up, un, pp, mhit(pp), mnext(pp), "R3/R5/R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule